// File: doc/BRIEF.md
# Input-Event Interrupt Controller

This block turns the filtered levels of eight input channels into prioritized interrupt requests. For each channel, software picks whether it is enabled. It also picks the mode: level match against a polarity bit, or change of state, which reacts to either edge. A separate group of pattern-select bits names the channels that take part in a word-match condition. That condition is merged into the top channel's event.

Events from enabled channels set bits in an 8-bit pending register. Software clears a bit by writing 1 to it. If the cause is still present, the bit sets again, so a persistent level keeps requesting. A global flag reports whether anything is pending. The request output is gated by a global enable. The index of the highest pending channel is encoded so that the matching vector can be looked up. All register writes use a strobe per register plus a shared data word and take effect at the next clock edge.

Top module: `inp_evt_irq`

## Requirements
- R1: Reset clears the pending register, the channel enables, polarities, mode bits, pattern-select bits and the global enable. After reset `pend` is 0, and `any_pend`, `irq` and `top_idx` are 0.
- R2: A channel in level mode (mode bit 0) with polarity 1 sets its pending bit at the clock edge after which its input is seen at 1, and keeps setting it while the input stays 1.
- R3: A channel in level mode with polarity 0 sets its pending bit while its input is 0.
- R4: A channel in change-of-state mode (mode bit 1) sets its pending bit one edge after its input differs from its value at the previous edge, for a rise or a fall, whatever its polarity. The bit stays set after the input settles.
- R5: A pending bit never becomes set while its channel enable bit is 0.
- R6: Writing `wdata` with `wr_pend` clears every pending bit whose `wdata` bit is 1 and leaves bits written with 0 unchanged. A bit whose cause is present at that edge stays set.
- R7: Pending bit 7 is also set when the pattern condition holds: every channel whose pattern-select bit is 1 has its input equal to its polarity bit. Channel 7 must be enabled for this.
- R8: With all pattern-select bits 0, the pattern condition never holds.
- R9: `top_idx` is the index of the highest set pending bit: channel 7 has the highest priority and channel 0 the lowest. `top_idx` is 0 when nothing is pending. Clearing the top bit moves `top_idx` to the next pending bit.
- R10: `any_pend` is 1 exactly when some pending bit is set, regardless of the global enable. `irq` equals `any_pend` when the global enable (bit 0 of `wdata` written with `wr_gen`) is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Filtered channel levels |
| wdata | input | 8 | Write data shared by all write strobes |
| wr_en | input | 1 | Load channel enables from wdata |
| wr_pol | input | 1 | Load polarities from wdata |
| wr_mode | input | 1 | Load mode bits from wdata (1 = change of state) |
| wr_pat | input | 1 | Load pattern-select bits from wdata |
| wr_pend | input | 1 | Write-one-to-clear the pending register |
| wr_gen | input | 1 | Load global enable from wdata bit 0 |
| pend | output | 8 | Pending status register |
| any_pend | output | 1 | Some pending bit is set |
| irq | output | 1 | Interrupt request |
| top_idx | output | 3 | Index of the highest pending channel |

## Verification
On every cycle, the assertions check three things: no pending bit rises on a disabled channel; an edge on an enabled change-of-state channel is latched at the next edge; and `top_idx` points at the highest set bit. They also check that `irq` never appears without both the global enable and a pending bit. The bench scenarios are needed for the rest. These cover the level-match results across every input word and the write-one-to-clear re-arm while a level persists. They also cover the pattern condition folded into bit 7, including the empty-selection case, and the reset clearing of the configuration registers, which only shows through later behaviour.

// File: rtl/inp_evt_irq.sv
module inp_evt_irq #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] wdata,
  input  logic           wr_en,
  input  logic           wr_pol,
  input  logic           wr_mode,
  input  logic           wr_pat,
  input  logic           wr_pend,
  input  logic           wr_gen,
  output logic [NCH-1:0] pend,
  output logic           any_pend,
  output logic           irq,
  output logic [IW-1:0]  top_idx
);
  logic [NCH-1:0] en_q, pol_q, mode_q, pat_q, prev_q, pend_q;
  logic           gen_q;
  logic [NCH-1:0] lvl_hit, cos_hit, evt, clr;
  logic           pat_hit;

  assign lvl_hit = ~(din ^ pol_q);
  assign cos_hit = din ^ prev_q;
  assign pat_hit = (pat_q != '0) && ((lvl_hit & pat_q) == pat_q);

  always_comb begin
    evt = (mode_q & cos_hit) | (~mode_q & lvl_hit);
    evt[NCH-1] = evt[NCH-1] | pat_hit;
  end

  assign clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      pat_q  <= '0;
      gen_q  <= 1'b0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      if (wr_mode) mode_q <= wdata;
      if (wr_pat)  pat_q  <= wdata;
      if (wr_gen)  gen_q  <= wdata[0];
      prev_q <= din;
      pend_q <= (pend_q & ~clr) | (evt & en_q);
    end
  end

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (pend_q[i]) top_idx = IW'(i);
  end

  assign pend     = pend_q;
  assign any_pend = |pend_q;
  assign irq      = gen_q & any_pend;
endmodule

module inp_evt_irq_chk #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] din,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] prev_q,
  input logic           gen_q,
  input logic [NCH-1:0] pend,
  input logic           any_pend,
  input logic           irq,
  input logic [IW-1:0]  top_idx
);
  // R5
  masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en_q)) == '0));

  // R4
  cos_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(en_q & mode_q & (din ^ prev_q))) ==
              $past(en_q & mode_q & (din ^ prev_q))));

  // R9
  top_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> ((pend >> top_idx) == NCH'(1)));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gen_q && any_pend && pend != '0));
endmodule

bind inp_evt_irq inp_evt_irq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .en_q(en_q), .mode_q(mode_q),
  .prev_q(prev_q), .gen_q(gen_q), .pend(pend), .any_pend(any_pend),
  .irq(irq), .top_idx(top_idx)
);

// File: tb/inp_evt_irq_test.sv
module inp_evt_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = '0, wdata = '0;
  logic       wr_en = 0, wr_pol = 0, wr_mode = 0, wr_pat = 0, wr_pend = 0, wr_gen = 0;
  logic [7:0] pend;
  logic       any_pend, irq;
  logic [2:0] top_idx;

  int errors = 0, checks = 0;

  logic [7:0] m_en, m_pol, m_mode, m_pat, m_prev, m_pend;
  logic       m_gen;

  inp_evt_irq uut (
    .clk(clk), .rst_n(rst_n), .din(din), .wdata(wdata),
    .wr_en(wr_en), .wr_pol(wr_pol), .wr_mode(wr_mode), .wr_pat(wr_pat),
    .wr_pend(wr_pend), .wr_gen(wr_gen),
    .pend(pend), .any_pend(any_pend), .irq(irq), .top_idx(top_idx)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_top(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic cyc();
    logic [7:0] ev, clr;
    logic       pm;
    pm  = (m_pat != 0) && (((din ~^ m_pol) & m_pat) == m_pat);
    ev  = (m_mode & (din ^ m_prev)) | (~m_mode & (din ~^ m_pol));
    ev[7] = ev[7] | pm;
    clr = wr_pend ? wdata : 8'h00;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_mode = 0; m_pat = 0; m_gen = 0; m_prev = 0; m_pend = 0;
    end else begin
      m_pend = (m_pend & ~clr) | (ev & m_en);
      if (wr_en)   m_en   = wdata;
      if (wr_pol)  m_pol  = wdata;
      if (wr_mode) m_mode = wdata;
      if (wr_pat)  m_pat  = wdata;
      if (wr_gen)  m_gen  = wdata[0];
      m_prev = din;
    end
    {wr_en, wr_pol, wr_mode, wr_pat, wr_pend, wr_gen} = '0;
  endtask

  task automatic outs(input string tag);
    chk({tag, " pend"}, pend, m_pend);
    chk({tag, " any_pend R10"}, any_pend, m_pend != 0);
    chk({tag, " irq R10"}, irq, m_gen && (m_pend != 0));
    chk({tag, " top_idx R9"}, top_idx, exp_top(m_pend));
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    wdata = d;
    case (which)
      0: wr_en = 1; 1: wr_pol = 1; 2: wr_mode = 1;
      3: wr_pat = 1; 4: wr_pend = 1; default: wr_gen = 1;
    endcase
    cyc();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_en = 0; m_pol = 0; m_mode = 0; m_pat = 0; m_gen = 0; m_prev = 0; m_pend = 0;
    #1;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    outs("R1 reset");

    // R2 R3: level mode sweep, mixed polarity
    wr(1, 8'hA5); wr(0, 8'hFF); wr(5, 8'h01);
    for (int v = 0; v < 256; v++) begin
      din = 8'(v);
      cyc();
      outs("R2 R3 level");
      wr(4, 8'hFF);
      outs("R6 rearm");
    end

    // R9: clearing top bit moves to next
    wr(1, 8'hFF); din = 8'h00; wr(0, 8'h00); wr(4, 8'hFF);
    wr(2, 8'hFF); wr(0, 8'hFF);
    din = 8'h8A; cyc(); outs("R4 R9 edge");
    cyc(); outs("R4 hold");
    wr(4, 8'h80); outs("R9 next");
    wr(4, 8'h00); outs("R6 zero write");
    wr(4, 8'h08); outs("R9 next2");

    // R4: falling edges, polarity irrelevant
    wr(4, 8'hFF); wr(1, 8'h00);
    din = 8'h00; cyc(); outs("R4 fall");
    cyc(); outs("R4 hold2");
    wr(4, 8'hFF); cyc(); outs("R6 cos cleared");

    // R10: global enable off
    wr(5, 8'h00);
    din = 8'h11; cyc(); outs("R10 gen off");

    // R5: disabled channels
    wr(4, 8'hFF); wr(2, 8'h00); wr(1, 8'hFF); wr(0, 8'h0F);
    for (int v = 0; v < 256; v += 17) begin
      din = 8'(v); cyc(); outs("R5 masked");
      wr(4, 8'hFF);
    end

    // R7 R8: pattern into bit 7
    din = 8'h00; wr(0, 8'h00); wr(2, 8'h80); wr(1, 8'h05); wr(4, 8'hFF);
    wr(0, 8'h80); wr(4, 8'hFF);
    wr(3, 8'h0F);
    for (int v = 0; v < 16; v++) begin
      din = 8'(v); cyc(); outs("R7 pattern");
      wr(4, 8'hFF);
    end
    wr(3, 8'h00);
    for (int v = 0; v < 16; v++) begin
      din = 8'(v); cyc(); outs("R8 empty pattern");
    end

    // R1: reset mid-run clears configuration
    wr(5, 8'h01); wr(2, 8'h00); wr(1, 8'hFF); wr(0, 8'hFF);
    din = 8'hFF; cyc(); outs("R1 pre");
    rst_n = 0; cyc(); rst_n = 1;
    outs("R1 after");
    din = 8'h00; cyc(); cyc(); outs("R1 cfg cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule